// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is the watchdog of a small 8-bit controller. It sits on the byte-wide register bus and holds two registers. One is a mode register that may be written once after each reset and sets the overflow period. The other is a service register that restarts the count only when a fixed key byte is written to it. The counter runs from a slow clock that is separate from the bus clock. Service requests and overflow events cross between the two clock domains through two-flop synchronizers.

The block raises one reset-request output that the chip reset controller consumes. Three things raise it: a counter overflow, a wrong key, and any misuse of the register protocol. Misuse here means a bit-level access to the service register, a bit-level write to the mode register, or a second mode write. The request is a fixed-length pulse. While the pulse is high, every register of the block is held in its reset state, so the write-once lock is free again afterwards. If the mode register is written with its stop bit set, the counter halts and every trap is disarmed.

Top module: `wdt_guard`

## Requirements
- R1: A byte write of 0xAC to address 0xFF49 restarts the counter from zero. Servicing more often than the overflow period never raises `rst_req`.
- R2: A byte write of any value other than 0xAC to 0xFF49 raises `rst_req` in the cycle after the write.
- R3: A read of 0xFF49 returns 0x9A on `bus_rdata` one cycle after the read strobe, whatever was written before.
- R4: A bit-level access (`bus_bit`=1, with read or write) to 0xFF49 raises `rst_req` in the following cycle.
- R5: The mode register at 0xFF48 resets to 0x67. The first byte write after reset is stored and reads back one cycle after a read strobe.
- R6: A second byte write to 0xFF48 raises `rst_req`, and so does any bit-level write to 0xFF48.
- R7: While mode bit 4 is 1, the watchdog is stopped. The counter does not advance. A wrong key, a bit access to 0xFF49 and further mode writes raise no reset, and further mode writes leave the stored value unchanged.
- R8: While running, the counter overflows after 2^(10+n) slow-clock cycles, where n is mode bits 2..0. The overflow raises `rst_req`.
- R9: `rst_req` is a pulse exactly 4 bus clocks long. After it ends, the mode register reads 0x67 and the write-once lock is released.
- R10: A write to any other address has no effect, and a read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset. Must be held for at least 3 slow-clock cycles. |
| lclk | input | 1 | Slow counter clock |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on `clk` |
| bus_rd | input | 1 | Read strobe, sampled on `clk` |
| bus_bit | input | 1 | Marks the access as bit-level (read-modify-write) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rst_req | output | 1 | Internal reset request pulse |

## Verification
The bench checks that a bit-level read of the service register is trapped while the watchdog runs and is harmless once it is stopped. A design that decoded only writes would miss the first case, and one that ignored the stop bit would reset in the second. It checks that a write to the mode register after the stop setting is dropped and the stored value survives. A design with the lock but no stop exemption would reset here, and one without the lock would overwrite the value. The overflow time is measured for two period settings inside tight windows, so an off-by-one in the period shift or a lost service request would land outside them. The bench also reads the mode register after each pulse, which exposes a lock or mode value that survived the pulse.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam logic [7:0] KEY_BYTE  = 8'hAC;
  localparam logic [7:0] SVC_READ  = 8'h9A;
  localparam logic [7:0] MODE_INIT = 8'h67;
  localparam int         STOP_BIT  = 4;
endpackage

// File: rtl/wdt_sync2.sv
module wdt_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    meta_q <= d;
    hold_q <= meta_q;
  end

  assign q = hold_q;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_guard_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'hFF48,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 16'hFF49,
  parameter int                SEL_W     = 3
) (
  input  logic              clk,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              bitop,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [SEL_W-1:0]  sel,
  output logic              stopped,
  output logic              locked,
  output logic              violation,
  output logic              svc_evt
);
  logic [7:0] mode_q;
  logic       lock_q;
  logic [7:0] rdata_q;
  logic       hit_mode;
  logic       hit_svc;
  logic       live;
  logic       bad_key;
  logic       svc_bit;
  logic       mode_again;
  logic       mode_bit;
  logic       mode_take;

  assign hit_mode = (addr == MODE_ADDR);
  assign hit_svc  = (addr == CLR_ADDR);
  assign live     = !soft_rst;
  assign stopped  = mode_q[STOP_BIT];
  assign sel      = mode_q[SEL_W-1:0];
  assign locked   = lock_q;

  assign bad_key    = wr && hit_svc && !bitop && (wdata != KEY_BYTE);
  assign svc_bit    = (wr || rd) && hit_svc && bitop;
  assign mode_again = wr && hit_mode && !bitop && lock_q;
  assign mode_bit   = wr && hit_mode && bitop;

  assign violation = live && !stopped && (bad_key || svc_bit || mode_again || mode_bit);
  assign svc_evt   = live && wr && hit_svc && !bitop && (wdata == KEY_BYTE);
  assign mode_take = live && wr && hit_mode && !bitop && !lock_q;

  always_ff @(posedge clk) begin
    if (soft_rst) begin
      mode_q <= MODE_INIT;
      lock_q <= 1'b0;
    end else if (mode_take) begin
      mode_q <= wdata;
      lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (soft_rst) begin
      rdata_q <= 8'h00;
    end else if (rd) begin
      if (hit_svc)
        rdata_q <= SVC_READ;
      else if (hit_mode)
        rdata_q <= mode_q;
      else
        rdata_q <= 8'h00;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_CLKS = 4
) (
  input  logic clk,
  input  logic hard_rst,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(PULSE_CLKS + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (!act_q) begin
      if (trig) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end
    end else if (cnt_q == CW'(PULSE_CLKS - 1)) begin
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/wdt_lcount.sv
module wdt_lcount #(
  parameter int BASE_LOG = 10,
  parameter int SEL_W    = 3
) (
  input  logic             lclk,
  input  logic             hrst,
  input  logic             req,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             ack,
  output logic             ovf_tgl
);
  localparam int CNT_W = BASE_LOG + (1 << SEL_W) - 1;
  localparam int SYN_W = SEL_W + 3;

  logic [SYN_W-1:0] syn_in;
  logic [SYN_W-1:0] syn_out;
  logic             l_rst;
  logic             l_req;
  logic             l_run;
  logic [SEL_W-1:0] l_sel;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;
  logic             ack_q;
  logic             ovf_q;

  assign syn_in = {hrst, req, run, sel};

  wdt_sync2 #(.W(SYN_W)) u_sync (
    .clk (lclk),
    .d   (syn_in),
    .q   (syn_out)
  );

  assign l_rst = syn_out[SYN_W-1];
  assign l_req = syn_out[SYN_W-2];
  assign l_run = syn_out[SYN_W-3];
  assign l_sel = syn_out[SEL_W-1:0];

  assign lim_m1 = (CNT_W'(1) << (BASE_LOG + int'(l_sel))) - CNT_W'(1);

  always_ff @(posedge lclk) begin
    if (l_rst) begin
      cnt_q <= '0;
      ack_q <= l_req;
      ovf_q <= 1'b0;
    end else if (l_req != ack_q) begin
      ack_q <= l_req;
      cnt_q <= '0;
    end else if (l_run) begin
      if (cnt_q >= lim_m1) begin
        cnt_q <= '0;
        ovf_q <= ~ovf_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ack     = ack_q;
  assign ovf_tgl = ovf_q;
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 16'hFF48,
  parameter logic [ADDR_W-1:0] CLR_ADDR   = 16'hFF49,
  parameter int                BASE_LOG   = 10,
  parameter int                SEL_W      = 3,
  parameter int                PULSE_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lclk,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_bit,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              rst_req
);
  logic             pulse_on;
  logic             soft_rst;
  logic [SEL_W-1:0] wd_sel;
  logic             wd_stopped;
  logic             wd_locked;
  logic             viol;
  logic             svc_evt;
  logic             trig;
  logic             ovf_evt;
  logic             req_q;
  logic             pend_q;
  logic             svc_any;
  logic             ack_l;
  logic             ack_s;
  logic             ovf_l;
  logic             ovf_s;
  logic             ovf_d;

  assign soft_rst = rst || pulse_on;

  wdt_regs #(
    .ADDR_W    (ADDR_W),
    .MODE_ADDR (MODE_ADDR),
    .CLR_ADDR  (CLR_ADDR),
    .SEL_W     (SEL_W)
  ) u_regs (
    .clk       (clk),
    .soft_rst  (soft_rst),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .rd        (bus_rd),
    .bitop     (bus_bit),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .sel       (wd_sel),
    .stopped   (wd_stopped),
    .locked    (wd_locked),
    .violation (viol),
    .svc_evt   (svc_evt)
  );

  // Service requests and pulses restart the slow counter through req/ack.
  assign svc_any = svc_evt || pulse_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      ovf_d  <= ovf_s;
    end else begin
      ovf_d <= ovf_s;
      if ((pend_q || svc_any) && (req_q == ack_s)) begin
        req_q  <= ~req_q;
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_q || svc_any;
      end
    end
  end

  wdt_sync2 #(.W(1)) u_ack_sync (
    .clk (clk),
    .d   (ack_l),
    .q   (ack_s)
  );

  wdt_sync2 #(.W(1)) u_ovf_sync (
    .clk (clk),
    .d   (ovf_l),
    .q   (ovf_s)
  );

  wdt_lcount #(
    .BASE_LOG (BASE_LOG),
    .SEL_W    (SEL_W)
  ) u_lcount (
    .lclk    (lclk),
    .hrst    (rst),
    .req     (req_q),
    .run     (!wd_stopped),
    .sel     (wd_sel),
    .ack     (ack_l),
    .ovf_tgl (ovf_l)
  );

  assign ovf_evt = (ovf_s ^ ovf_d) && !wd_stopped && !pulse_on;
  assign trig    = viol || ovf_evt;

  wdt_pulse #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
    .clk      (clk),
    .hard_rst (rst),
    .trig     (trig),
    .active   (pulse_on)
  );

  assign rst_req = pulse_on;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 16'hFF48,
  parameter logic [ADDR_W-1:0] CLR_ADDR   = 16'hFF49,
  parameter int                PULSE_CLKS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_bit,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              rst_req,
  input logic              stopped,
  input logic              locked
);
  localparam int HW = $clog2(PULSE_CLKS + 1) + 1;

  logic [HW-1:0] hcnt_q;

  always_ff @(posedge clk) begin
    if (rst || !rst_req)
      hcnt_q <= '0;
    else
      hcnt_q <= hcnt_q + 1'b1;
  end

  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (hcnt_q < HW'(PULSE_CLKS))); // R9

  AST_PULSE_MIN: assert property (@(posedge clk) disable iff (rst)
    (!rst_req && $past(rst_req) && !$past(rst)) |-> (hcnt_q == HW'(PULSE_CLKS))); // R9

  AST_LOCK_FREED: assert property (@(posedge clk) disable iff (rst)
    (!rst_req && $past(rst_req) && !$past(rst)) |-> !locked); // R9

  AST_SVC_READBACK: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == CLR_ADDR && !rst_req && !rst) |-> (bus_rdata == 8'h9A)); // R3

  AST_BAD_KEY: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && !bus_bit && bus_addr == CLR_ADDR && bus_wdata != 8'hAC
          && !stopped && !rst_req && !rst) |-> rst_req); // R2

  AST_BIT_TRAP: assert property (@(posedge clk) disable iff (rst)
    $past((bus_wr || bus_rd) && bus_bit && bus_addr == CLR_ADDR
          && !stopped && !rst_req && !rst) |-> rst_req); // R4

  AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && !bus_bit && bus_addr == MODE_ADDR && locked
          && !stopped && !rst_req && !rst) |-> rst_req); // R6

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rst_req && !$past(rst_req) && !$past(rst)) |-> !$past(stopped)); // R7
endmodule

bind wdt_guard wdt_guard_chk #(
  .ADDR_W     (ADDR_W),
  .MODE_ADDR  (MODE_ADDR),
  .CLR_ADDR   (CLR_ADDR),
  .PULSE_CLKS (PULSE_CLKS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_bit   (bus_bit),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .rst_req   (rst_req),
  .stopped   (wd_stopped),
  .locked    (wd_locked)
);

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
  localparam logic [15:0] MODE_A = 16'hFF48;
  localparam logic [15:0] SVC_A  = 16'hFF49;
  localparam logic [15:0] OTHER_A = 16'hFF4A;

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic        bitop;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic        chk_rd;
    logic [7:0]  exp_rd;
    logic        exp_rst;
    logic [23:0] tag;
  } step_t;

  localparam int NSTEP = 22;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b0, 1'b1, 1'b0, SVC_A,   8'h00, 1'b1, 8'h9A, 1'b0, "R3"},
    '{1'b0, 1'b1, 1'b0, MODE_A,  8'h00, 1'b1, 8'h67, 1'b0, "R5"},
    '{1'b1, 1'b0, 1'b0, SVC_A,   8'hAC, 1'b0, 8'h00, 1'b0, "R1"},
    '{1'b1, 1'b0, 1'b0, SVC_A,   8'h55, 1'b0, 8'h00, 1'b1, "R2"},
    '{1'b0, 1'b1, 1'b0, MODE_A,  8'h00, 1'b1, 8'h67, 1'b0, "R9"},
    '{1'b1, 1'b0, 1'b0, MODE_A,  8'h05, 1'b0, 8'h00, 1'b0, "R5"},
    '{1'b0, 1'b1, 1'b0, MODE_A,  8'h00, 1'b1, 8'h05, 1'b0, "R5"},
    '{1'b1, 1'b0, 1'b0, MODE_A,  8'h05, 1'b0, 8'h00, 1'b1, "R6"},
    '{1'b0, 1'b1, 1'b0, MODE_A,  8'h00, 1'b1, 8'h67, 1'b0, "R9"},
    '{1'b1, 1'b0, 1'b1, MODE_A,  8'h03, 1'b0, 8'h00, 1'b1, "R6"},
    '{1'b0, 1'b1, 1'b1, SVC_A,   8'h00, 1'b0, 8'h00, 1'b1, "R4"},
    '{1'b1, 1'b0, 1'b1, SVC_A,   8'hAC, 1'b0, 8'h00, 1'b1, "R4"},
    '{1'b1, 1'b0, 1'b0, SVC_A,   8'h00, 1'b0, 8'h00, 1'b1, "R2"},
    '{1'b1, 1'b0, 1'b0, MODE_A,  8'h18, 1'b0, 8'h00, 1'b0, "R7"},
    '{1'b1, 1'b0, 1'b0, SVC_A,   8'h11, 1'b0, 8'h00, 1'b0, "R7"},
    '{1'b1, 1'b0, 1'b1, SVC_A,   8'hAC, 1'b0, 8'h00, 1'b0, "R7"},
    '{1'b1, 1'b0, 1'b0, MODE_A,  8'h00, 1'b0, 8'h00, 1'b0, "R7"},
    '{1'b0, 1'b1, 1'b0, MODE_A,  8'h00, 1'b1, 8'h18, 1'b0, "R7"},
    '{1'b0, 1'b1, 1'b1, SVC_A,   8'h00, 1'b1, 8'h9A, 1'b0, "R7"},
    '{1'b1, 1'b0, 1'b0, OTHER_A, 8'h3C, 1'b0, 8'h00, 1'b0, "R10"},
    '{1'b0, 1'b1, 1'b0, OTHER_A, 8'h00, 1'b1, 8'h00, 1'b0, "R10"},
    '{1'b0, 1'b1, 1'b0, SVC_A,   8'h00, 1'b1, 8'h9A, 1'b0, "R3"}
  };

  logic        clk = 1'b0;
  logic        lclk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_bit = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        rst_req;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;
  always #16 lclk = ~lclk;

  wdt_guard dut_i (
    .clk       (clk),
    .rst       (rst),
    .lclk      (lclk),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_bit   (bus_bit),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: run did not finish, actual %0d expected <190000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic w, input logic r, input logic b,
                        input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_bit = b; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_bit = 1'b0;
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (20) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (rst_req && n < 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_req(input int limit, output int t);
    t = 0;
    while (!rst_req && t < limit) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    int n;
    int t;
    bit seen;
    hard_reset();
    // Reset state
    check(rst_req == 1'b0, "R9", rst_req, 0);
    bus_op(1'b0, 1'b1, 1'b0, MODE_A, 8'h00);
    check(bus_rdata == 8'h67, "R5", bus_rdata, 8'h67);

    // Table walk
    for (int i = 0; i < NSTEP; i++) begin
      bus_op(STEPS[i].wr, STEPS[i].rd, STEPS[i].bitop, STEPS[i].addr, STEPS[i].wd);
      check(rst_req == STEPS[i].exp_rst, $sformatf("%s step %0d rst_req", STEPS[i].tag, i),
            rst_req, STEPS[i].exp_rst);
      if (STEPS[i].chk_rd)
        check(bus_rdata == STEPS[i].exp_rd, $sformatf("%s step %0d rdata", STEPS[i].tag, i),
              bus_rdata, STEPS[i].exp_rd);
      if (rst_req) begin
        pulse_len(n);
        check(n == 4, $sformatf("R9 step %0d pulse length", i), n, 4);
      end
      repeat (2) @(negedge clk);
    end

    // Overflow with n=0 (R8)
    hard_reset();
    bus_op(1'b1, 1'b0, 1'b0, MODE_A, 8'h00);
    bus_op(1'b1, 1'b0, 1'b0, SVC_A, 8'hAC);
    wait_req(6000, t);
    check(t >= 4000 && t <= 4250, "R8 period n=0", t, 4110);
    pulse_len(n);
    check(n == 4, "R9 overflow pulse length", n, 4);
    bus_op(1'b0, 1'b1, 1'b0, MODE_A, 8'h00);
    check(bus_rdata == 8'h67, "R9 mode after pulse", bus_rdata, 8'h67);
    bus_op(1'b1, 1'b0, 1'b0, MODE_A, 8'h10);
    check(rst_req == 1'b0, "R9 lock released after pulse", rst_req, 0);

    // Regular service holds off overflow (R1)
    hard_reset();
    bus_op(1'b1, 1'b0, 1'b0, MODE_A, 8'h00);
    seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      bus_op(1'b1, 1'b0, 1'b0, SVC_A, 8'hAC);
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        if (rst_req) seen = 1'b1;
      end
    end
    check(seen == 1'b0, "R1 serviced counter never overflows", seen, 0);

    // Stopped counter never overflows (R7)
    hard_reset();
    bus_op(1'b1, 1'b0, 1'b0, MODE_A, 8'h10);
    bus_op(1'b1, 1'b0, 1'b0, SVC_A, 8'hAC);
    seen = 1'b0;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if (rst_req) seen = 1'b1;
    end
    check(seen == 1'b0, "R7 stopped counter silent", seen, 0);

    // Overflow with n=1 (R8)
    hard_reset();
    bus_op(1'b1, 1'b0, 1'b0, MODE_A, 8'h01);
    bus_op(1'b1, 1'b0, 1'b0, SVC_A, 8'hAC);
    wait_req(10000, t);
    check(t >= 8100 && t <= 8350, "R8 period n=1", t, 8210);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule